// File: doc/BRIEF.md
# Converter Offset and Range Adapter

This block sits between a single-supply converter pair and a signed fixed-point filter core. Converter codes are unsigned and centred on mid-scale, while the core works on two's-complement words that are wider than the converter. On the way in, the adapter removes the mid-scale offset from each ADC code and sign-extends the signed result to the core's word width. On the way out, it limits the core's already rounded result to the signed converter range, flags any clipping, and adds the mid-scale offset back to form an unsigned DAC code.

Both paths are registered once on each sample strobe and hold their values between strobes. The filter arithmetic is not part of the block. The converter width and the core width are parameters, and the core width must be at least the converter width.

Top module: `codec_bridge`

## Requirements
- R1: On a strobe, the ADC code A (ADC_W bits, unsigned) is converted to the signed value A - 2^(ADC_W-1). A code of exactly 2^(ADC_W-1) gives zero, code 0 gives -2^(ADC_W-1), and the all-ones code gives 2^(ADC_W-1)-1.
- R2: The signed input value is sign-extended to CORE_W bits on core_din, so negative values keep their meaning (for example, -1 is all ones).
- R3: A core result above 2^(ADC_W-1)-1 is limited to 2^(ADC_W-1)-1, so dac_code becomes all ones.
- R4: A core result below -2^(ADC_W-1) is limited to -2^(ADC_W-1), so dac_code becomes zero.
- R5: A core result V inside the signed ADC_W-bit range gives dac_code = V + 2^(ADC_W-1). Zero gives mid-scale, and the range limits 2^(ADC_W-1)-1 and -2^(ADC_W-1) pass through unflagged as all ones and zero.
- R6: sat_flag is 1 after a strobe whose core result was limited by R3 or R4, and 0 after a strobe whose result was in range.
- R7: core_din, dac_code and sat_flag take new values only on a clock edge where smp_stb is high, and they are valid one cycle after that edge. Without a strobe they hold, whatever adc_code and core_dout do.
- R8: While reset is applied, and after it is released, until the first strobe: core_din is 0, dac_code is 2^(ADC_W-1) and sat_flag is 0. Reset is applied asynchronously and released in step with the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_stb | input | 1 | Sample strobe: both paths capture on this edge |
| adc_code | input | ADC_W | Unsigned ADC code, centred on mid-scale |
| core_din | output | CORE_W | Signed, sign-extended sample for the filter core |
| core_dout | input | CORE_W | Signed, rounded result from the filter core |
| dac_code | output | ADC_W | Unsigned DAC code, centred on mid-scale |
| sat_flag | output | 1 | Set when the last strobed core result was limited |

## Verification
Every result is due one clock after the edge that sampled smp_stb high, for both the input path and the output path. The driver raises the strobe for one cycle on a falling edge and queues the expected core word, DAC code and flag. The monitor sees the strobe on the next rising edge and compares the outputs on the falling edge that follows, so each comparison falls midway through the cycle in which the result is valid. Hold behaviour is checked by changing both data inputs without a strobe and reading the outputs again several cycles later. The reset values are read once reset has been released and the internal release has had time to pass through.

// File: rtl/codec_bridge_pkg.sv
package codec_bridge_pkg;

  // Number of flops that release the internal reset in step with the clock.
  localparam int RST_SYNC_STAGES = 2;

  // Result of the range check on a core sample.
  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_HI   = 2'd1,
    CLAMP_LO   = 2'd2
  } clamp_e;

endpackage

// File: rtl/cb_rst_sync.sv
module cb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/cb_ingress.sv
module cb_ingress #(
  parameter int ADC_W  = 12,
  parameter int CORE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [ADC_W-1:0]  code,
  output logic [CORE_W-1:0] wide
);

  localparam int EXT_W = CORE_W - ADC_W;

  logic [ADC_W-1:0]  centred;
  logic [CORE_W-1:0] widened;
  logic [CORE_W-1:0] wide_d;
  logic [CORE_W-1:0] wide_q;

  // Subtracting half scale modulo 2^ADC_W flips the top bit.
  assign centred = {~code[ADC_W-1], code[ADC_W-2:0]};

  generate
    if (EXT_W > 0) begin : g_extend
      assign widened = {{EXT_W{centred[ADC_W-1]}}, centred};
    end else begin : g_same
      assign widened = centred;
    end
  endgenerate

  always_comb begin
    wide_d = wide_q;
    if (stb) begin
      wide_d = widened;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= '0;
    end else begin
      wide_q <= wide_d;
    end
  end

  assign wide = wide_q;

endmodule

// File: rtl/cb_egress.sv
module cb_egress
  import codec_bridge_pkg::*;
#(
  parameter int ADC_W  = 12,
  parameter int CORE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [CORE_W-1:0] result,
  output logic [ADC_W-1:0]  code,
  output logic              clipped
);

  localparam int HEAD_W = CORE_W - ADC_W + 1;
  localparam logic signed [CORE_W-1:0] HI_LIM = {{HEAD_W{1'b0}}, {(ADC_W-1){1'b1}}};
  localparam logic signed [CORE_W-1:0] LO_LIM = {{HEAD_W{1'b1}}, {(ADC_W-1){1'b0}}};
  localparam logic [ADC_W-1:0] MID_CODE = {1'b1, {(ADC_W-1){1'b0}}};

  clamp_e           status;
  logic [ADC_W-1:0] limited;
  logic [ADC_W-1:0] code_d;
  logic [ADC_W-1:0] code_q;
  logic             clip_d;
  logic             clip_q;

  always_comb begin
    if ($signed(result) > HI_LIM) begin
      status = CLAMP_HI;
    end else if ($signed(result) < LO_LIM) begin
      status = CLAMP_LO;
    end else begin
      status = CLAMP_NONE;
    end
  end

  always_comb begin
    case (status)
      CLAMP_HI: limited = {1'b0, {(ADC_W-1){1'b1}}};
      CLAMP_LO: limited = {1'b1, {(ADC_W-1){1'b0}}};
      default:  limited = result[ADC_W-1:0];
    endcase
  end

  always_comb begin
    code_d = code_q;
    clip_d = clip_q;
    if (stb) begin
      // Adding half scale modulo 2^ADC_W flips the top bit.
      code_d = {~limited[ADC_W-1], limited[ADC_W-2:0]};
      clip_d = (status != CLAMP_NONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= MID_CODE;
      clip_q <= 1'b0;
    end else begin
      code_q <= code_d;
      clip_q <= clip_d;
    end
  end

  assign code    = code_q;
  assign clipped = clip_q;

endmodule

// File: rtl/codec_bridge.sv
module codec_bridge
  import codec_bridge_pkg::*;
#(
  parameter int ADC_W  = 12,
  parameter int CORE_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [ADC_W-1:0]  adc_code,
  output logic [CORE_W-1:0] core_din,
  input  logic [CORE_W-1:0] core_dout,
  output logic [ADC_W-1:0]  dac_code,
  output logic              sat_flag
);

  logic rst_sync_n;

  cb_rst_sync #(
    .STAGES(RST_SYNC_STAGES)
  ) rst_sync_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  cb_ingress #(
    .ADC_W (ADC_W),
    .CORE_W(CORE_W)
  ) ingress_i (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .stb  (smp_stb),
    .code (adc_code),
    .wide (core_din)
  );

  cb_egress #(
    .ADC_W (ADC_W),
    .CORE_W(CORE_W)
  ) egress_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .stb    (smp_stb),
    .result (core_dout),
    .code   (dac_code),
    .clipped(sat_flag)
  );

endmodule

// File: rtl/codec_bridge_chk.sv
module codec_bridge_chk #(
  parameter int ADC_W  = 12,
  parameter int CORE_W = 24
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              smp_stb,
  input logic [ADC_W-1:0]  adc_code,
  input logic [CORE_W-1:0] core_din,
  input logic [CORE_W-1:0] core_dout,
  input logic [ADC_W-1:0]  dac_code,
  input logic              sat_flag
);

  localparam logic [ADC_W-1:0] MID = {1'b1, {(ADC_W-1){1'b0}}};
  localparam logic signed [CORE_W-1:0] HI = CORE_W'((64'sd1 <<< (ADC_W-1)) - 64'sd1);
  localparam logic signed [CORE_W-1:0] LO = CORE_W'(-(64'sd1 <<< (ADC_W-1)));

  logic [ADC_W-1:0] restored;
  logic             head_ok;

  assign restored = ADC_W'(core_din[ADC_W-1:0] + MID);
  assign head_ok  = (core_din[CORE_W-1:ADC_W-1] == '0) || (core_din[CORE_W-1:ADC_W-1] == '1);

  // R1: the low word plus half scale gives back the strobed ADC code
  a_r1_offset_removed: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(smp_stb) |-> restored == $past(adc_code));

  // R2: bits above the converter width copy its sign
  a_r2_sign_extended: assert property (@(posedge clk) disable iff (!rst_sync_n)
    head_ok);

  // R3: results above the range give a full-scale code and the flag
  a_r3_upper_clamp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(smp_stb) && ($signed($past(core_dout)) > HI)) |-> (dac_code == '1) && sat_flag);

  // R4: results below the range give a zero code and the flag
  a_r4_lower_clamp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(smp_stb) && ($signed($past(core_dout)) < LO)) |-> (dac_code == '0) && sat_flag);

  // R6: an in-range sample leaves the flag low
  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(smp_stb) && ($signed($past(core_dout)) <= HI) && ($signed($past(core_dout)) >= LO))
      |-> !sat_flag);

  // R7: without a strobe all outputs hold
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$past(smp_stb) |-> ($stable(core_din) && $stable(dac_code) && $stable(sat_flag)));

endmodule

bind codec_bridge codec_bridge_chk #(
  .ADC_W (ADC_W),
  .CORE_W(CORE_W)
) chk_i (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .smp_stb   (smp_stb),
  .adc_code  (adc_code),
  .core_din  (core_din),
  .core_dout (core_dout),
  .dac_code  (dac_code),
  .sat_flag  (sat_flag)
);

// File: tb/codec_bridge_tb_top.sv
module codec_bridge_tb_top;

  localparam int N = 12;
  localparam int M = 24;
  localparam int HALF = 1 << (N-1);

  typedef struct {
    logic [M-1:0] din;
    logic [N-1:0] dac;
    logic         sat;
    string        req;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic         smp_stb;
  logic [N-1:0] adc_code;
  logic [M-1:0] core_din;
  logic [M-1:0] core_dout;
  logic [N-1:0] dac_code;
  logic         sat_flag;

  int   checks;
  int   fails;
  bit   done;
  exp_t sb[$];
  exp_t last_sent;

  codec_bridge #(.ADC_W(N), .CORE_W(M)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_stb  (smp_stb),
    .adc_code (adc_code),
    .core_din (core_din),
    .core_dout(core_dout),
    .dac_code (dac_code),
    .sat_flag (sat_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(logic [N-1:0] a, logic [M-1:0] c, string req);
    exp_t   e;
    longint v;
    v = longint'(a) - HALF;
    e.din = M'(v);
    v = longint'($signed(c));
    e.sat = 1'b0;
    if (v > HALF - 1) begin v = HALF - 1; e.sat = 1'b1; end
    if (v < -HALF)    begin v = -HALF;    e.sat = 1'b1; end
    e.dac = N'(v + HALF);
    e.req = req;
    return e;
  endfunction

  task automatic send(logic [N-1:0] a, logic [M-1:0] c, string req);
    @(negedge clk);
    adc_code  = a;
    core_dout = c;
    smp_stb   = 1'b1;
    last_sent = model(a, c, req);
    sb.push_back(last_sent);
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  // Monitor: result is due one cycle after the strobing edge.
  initial begin
    forever begin
      @(posedge clk);
      if (smp_stb && rst_n) begin
        exp_t e;
        @(negedge clk);
        if (sb.size() == 0) begin
          check("R7", "unexpected result", 1, 0);
        end else begin
          e = sb.pop_front();
          check(e.req, "core_din", longint'(core_din), longint'(e.din));
          check(e.req, "dac_code", longint'(dac_code), longint'(e.dac));
          check(e.req, "sat_flag", longint'(sat_flag), longint'(e.sat));
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    smp_stb = 1'b0;
    adc_code = '0;
    core_dout = '0;
    repeat (3) @(negedge clk);
    // R8: values while in reset
    check("R8", "core_din in reset", longint'(core_din), 0);
    check("R8", "dac_code in reset", longint'(dac_code), HALF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8: values after release, before any strobe
    check("R8", "core_din after reset", longint'(core_din), 0);
    check("R8", "dac_code after reset", longint'(dac_code), HALF);
    check("R8", "sat_flag after reset", longint'(sat_flag), 0);

    // R1 / R5: mid-scale and zero
    send(N'(HALF), M'(0), "R1_R5");
    // R1 / R2: code 0 -> most negative, sign extended
    send(N'(0), M'(100), "R2");
    send(N'(HALF - 1), M'(-1), "R2");
    send(N'((1 << N) - 1), M'(HALF - 1), "R5");
    send(N'(1234), M'(-HALF), "R5");
    // R3 / R6: just above the top of the range
    send(N'(3000), M'(HALF), "R3");
    send(N'(5), M'(-7), "R6");
    // R4 / R6: just below the bottom of the range
    send(N'(77), M'(-HALF - 1), "R4");
    send(N'(4000), M'({1'b0, {(M-1){1'b1}}}), "R3");
    send(N'(HALF + 1), M'({1'b1, {(M-1){1'b0}}}), "R4");
    send(N'(HALF), M'(300), "R6");

    // R7: back-to-back strobes
    @(negedge clk);
    adc_code = N'(10); core_dout = M'(20); smp_stb = 1'b1;
    sb.push_back(model(N'(10), M'(20), "R7"));
    @(negedge clk);
    adc_code = N'(2500); core_dout = M'(99999); smp_stb = 1'b1;
    last_sent = model(N'(2500), M'(99999), "R7");
    sb.push_back(last_sent);
    @(negedge clk);
    smp_stb = 1'b0;

    // R7: inputs change without a strobe; outputs must hold
    adc_code = N'(1);
    core_dout = M'(-5000);
    repeat (4) @(negedge clk);
    check("R7", "core_din hold", longint'(core_din), longint'(last_sent.din));
    check("R7", "dac_code hold", longint'(dac_code), longint'(last_sent.dac));
    check("R7", "sat_flag hold", longint'(sat_flag), longint'(last_sent.sat));

    repeat (3) @(negedge clk);
    check("R7", "queue drained", longint'(sb.size()), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule